// File: doc/BRIEF.md
# Packed Signed Saturating Adder

This block adds two 256-bit packed operands lane by lane as signed integers. Each lane result is clamped to the signed range of the lane rather than wrapped. A size input chooses 8-bit or 16-bit lanes. A form input chooses how wide the result is:

- a 128-bit form that keeps the upper half of the old destination,
- a 128-bit form that clears the upper half,
- a full 256-bit form.

In the keeping form, the first source is the old destination value.

Operands are captured on a clock edge where `in_valid` is high. One cycle later the result appears together with one saturation flag per lane, and `out_valid` is raised. The flags serve for debug. The operation reports no exception of any kind.

Top module: `sat_simd_add`

## Requirements
- R1: In byte mode (`size_sel`=0), byte lane i is bits [8i+7:8i]. It holds the signed sum of the same bytes of `src_a` and `src_b` whenever that sum fits in -128..127.
- R2: In word mode (`size_sel`=1), word lane i is bits [16i+15:16i]. It holds the signed 16-bit sum whenever that sum fits in -32768..32767, with the carry crossing between the two bytes of the word.
- R3: In byte mode, no carry passes from one byte lane into the next. For example, 0x00FF plus 0x0001 gives 0x0000.
- R4: A sum above the lane maximum gives 0x7F for a byte lane or 0x7FFF for a word lane. A sum below the lane minimum gives 0x80 or 0x8000.
- R5: With `mode_sel` = 2'b10 or 2'b11, every lane across bits [255:0] is computed. That is 32 byte lanes or 16 word lanes.
- R6: With `mode_sel` = 2'b01, only the low 128 bits are computed, and result bits [255:128] are zero.
- R7: With `mode_sel` = 2'b00, only the low 128 bits are computed, and result bits [255:128] equal `src_a[255:128]`.
- R8: `sat_flags[i]` is 1 exactly when lane i was clamped. Flag bits of lanes that are not computed are 0. These are the bits at and above the lane count of the chosen form and size.
- R9: `out_valid` is high in the cycle after each edge where `in_valid` is high, and low otherwise. `result` and `sat_flags` update only at such an edge and hold otherwise.
- R10: `rst_n` low clears `out_valid` at once. After `rst_n` rises, the block leaves reset on the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| in_valid | input | 1 | Capture operands this edge |
| size_sel | input | 1 | 0 = byte lanes, 1 = word lanes |
| mode_sel | input | 2 | 00 keep upper, 01 zero upper, 1x full width |
| src_a | input | 256 | First source, old destination in keep form |
| src_b | input | 256 | Second source |
| out_valid | output | 1 | Result valid |
| result | output | 256 | Saturated lane sums |
| sat_flags | output | 32 | Per-lane clamp flags, lane i at bit i |

## Verification
The assertions take for granted that `in_valid`, `size_sel`, `mode_sel` and both sources are known and steady around each capture edge. They also assume `in_valid` stays low until the internal reset has been released, because the upper-half and flag properties compare against operand values from the capture cycle. The bench drives every input on the falling edge and holds `in_valid` low through reset and for several cycles after it. It sweeps every pair of byte values and a set of word corner values, and adds pseudo-random operands in all forms.

// File: rtl/satadd_pkg.sv
package satadd_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  typedef enum logic {
    LN_BYTE = 1'b0,
    LN_WORD = 1'b1
  } lane_size_e;

  typedef enum logic [1:0] {
    FM_KEEP  = 2'b00,
    FM_ZERO  = 2'b01,
    FM_FULL  = 2'b10,
    FM_FULLB = 2'b11
  } form_e;
endpackage

// File: rtl/satadd_rst_sync.sv
module satadd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/satadd_seg16.sv
// One 16-bit segment: two byte lanes or one word lane.
module satadd_seg16 (
  input  logic        word_mode,
  input  logic [15:0] a,
  input  logic [15:0] b,
  output logic [15:0] sum,
  output logic        flag_lo,
  output logic        flag_hi
);
  logic [8:0] lo_sum;
  logic       cin_hi;
  logic [7:0] hi_sum;
  logic       ovf_lo;
  logic       ovf_hi;

  always_comb begin
    lo_sum = {1'b0, a[7:0]} + {1'b0, b[7:0]};
    // carry joins the two bytes only in word mode
    cin_hi = word_mode & lo_sum[8];
    hi_sum = a[15:8] + b[15:8] + {7'd0, cin_hi};
    ovf_lo = (a[7] == b[7]) && (lo_sum[7] != a[7]);
    ovf_hi = (a[15] == b[15]) && (hi_sum[7] != a[15]);

    if (word_mode) begin
      sum     = ovf_hi ? (a[15] ? 16'h8000 : 16'h7FFF) : {hi_sum, lo_sum[7:0]};
      flag_lo = ovf_hi;
      flag_hi = 1'b0;
    end else begin
      sum[7:0]  = ovf_lo ? (a[7] ? 8'h80 : 8'h7F) : lo_sum[7:0];
      sum[15:8] = ovf_hi ? (a[15] ? 8'h80 : 8'h7F) : hi_sum;
      flag_lo   = ovf_lo;
      flag_hi   = ovf_hi;
    end
  end
endmodule

// File: rtl/satadd_lane_array.sv
module satadd_lane_array #(
  parameter int DATA_W = 256
) (
  input  logic                 word_mode,
  input  logic [DATA_W-1:0]    a,
  input  logic [DATA_W-1:0]    b,
  output logic [DATA_W-1:0]    sum,
  output logic [DATA_W/16-1:0] flag_lo,
  output logic [DATA_W/16-1:0] flag_hi
);
  localparam int NSEG = DATA_W / 16;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    satadd_seg16 u_seg (
      .word_mode (word_mode),
      .a         (a[16*k +: 16]),
      .b         (b[16*k +: 16]),
      .sum       (sum[16*k +: 16]),
      .flag_lo   (flag_lo[k]),
      .flag_hi   (flag_hi[k])
    );
  end
endmodule

// File: rtl/satadd_merge.sv
module satadd_merge
  import satadd_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  form_e                form,
  input  lane_size_e           lane_size,
  input  logic [DATA_W-1:0]    prior,
  input  logic [DATA_W-1:0]    sum,
  input  logic [DATA_W/16-1:0] flag_lo,
  input  logic [DATA_W/16-1:0] flag_hi,
  output logic [DATA_W-1:0]    res,
  output logic [DATA_W/8-1:0]  flags
);
  localparam int HALF  = DATA_W / 2;
  localparam int NSEG  = DATA_W / WORD_W;
  localparam int LANES = DATA_W / BYTE_W;

  logic             wide;
  logic [LANES-1:0] packed_flags;
  int               active;

  always_comb begin
    wide = form[1];
    res[HALF-1:0] = sum[HALF-1:0];
    unique case (form)
      FM_KEEP: res[DATA_W-1:HALF] = prior[DATA_W-1:HALF];
      FM_ZERO: res[DATA_W-1:HALF] = '0;
      default: res[DATA_W-1:HALF] = sum[DATA_W-1:HALF];
    endcase
  end

  always_comb begin
    packed_flags = '0;
    for (int k = 0; k < NSEG; k++) begin
      if (lane_size == LN_WORD) begin
        packed_flags[k] = flag_lo[k];
      end else begin
        packed_flags[2*k]   = flag_lo[k];
        packed_flags[2*k+1] = flag_hi[k];
      end
    end
    if (lane_size == LN_WORD) active = wide ? NSEG : NSEG / 2;
    else                      active = wide ? LANES : LANES / 2;
    for (int i = 0; i < LANES; i++) flags[i] = packed_flags[i] && (i < active);
  end
endmodule

// File: rtl/sat_simd_add.sv
module sat_simd_add
  import satadd_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                size_sel,
  input  logic [1:0]          mode_sel,
  input  logic [DATA_W-1:0]   src_a,
  input  logic [DATA_W-1:0]   src_b,
  output logic                out_valid,
  output logic [DATA_W-1:0]   result,
  output logic [DATA_W/8-1:0] sat_flags
);
  localparam int NSEG  = DATA_W / WORD_W;
  localparam int LANES = DATA_W / BYTE_W;

  logic              rst_sync_n;
  logic [DATA_W-1:0] sum_w;
  logic [NSEG-1:0]   flo_w;
  logic [NSEG-1:0]   fhi_w;
  logic [DATA_W-1:0] res_d;
  logic [LANES-1:0]  flag_d;
  logic              valid_d;
  logic              valid_q;
  logic [DATA_W-1:0] res_q;
  logic [LANES-1:0]  flag_q;
  lane_size_e        size_e;
  form_e             form_v;

  assign size_e = lane_size_e'(size_sel);
  assign form_v = form_e'(mode_sel);

  satadd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  satadd_lane_array #(.DATA_W(DATA_W)) u_lanes (
    .word_mode (size_sel),
    .a         (src_a),
    .b         (src_b),
    .sum       (sum_w),
    .flag_lo   (flo_w),
    .flag_hi   (fhi_w)
  );

  satadd_merge #(.DATA_W(DATA_W)) u_merge (
    .form      (form_v),
    .lane_size (size_e),
    .prior     (src_a),
    .sum       (sum_w),
    .flag_lo   (flo_w),
    .flag_hi   (fhi_w),
    .res       (res_d),
    .flags     (flag_d)
  );

  always_comb valid_d = in_valid;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      res_q  <= res_d;
      flag_q <= flag_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign sat_flags = flag_q;
endmodule

// File: rtl/sat_simd_add_chk.sv
module sat_simd_add_chk #(
  parameter int DATA_W = 256
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                size_sel,
  input logic [1:0]          mode_sel,
  input logic [DATA_W-1:0]   src_a,
  input logic                out_valid,
  input logic [DATA_W-1:0]   result,
  input logic [DATA_W/8-1:0] sat_flags
);
  localparam int HALF  = DATA_W / 2;
  localparam int LANES = DATA_W / 8;
  localparam int NSEG  = DATA_W / 16;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(sat_flags)); // R9
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b01) |=> result[DATA_W-1:HALF] == '0); // R6
  AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode_sel == 2'b00) |=> result[DATA_W-1:HALF] == $past(src_a[DATA_W-1:HALF])); // R7
  AST_NARROW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_sel[1]) |=> sat_flags[LANES-1:LANES/2] == '0); // R8
  AST_WORD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_sel) |=> sat_flags[LANES-1:NSEG] == '0); // R8
  AST_BYTE0_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !size_sel) |=> (!sat_flags[0] || result[7:0] == 8'h7F || result[7:0] == 8'h80)); // R4
endmodule

bind sat_simd_add sat_simd_add_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .in_valid  (in_valid),
  .size_sel  (size_sel),
  .mode_sel  (mode_sel),
  .src_a     (src_a),
  .out_valid (out_valid),
  .result    (result),
  .sat_flags (sat_flags)
);

// File: tb/sat_simd_add_bench.sv
module sat_simd_add_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         size_sel;
  logic [1:0]   mode_sel;
  logic [255:0] src_a;
  logic [255:0] src_b;
  logic         out_valid;
  logic [255:0] result;
  logic [31:0]  sat_flags;

  int checks = 0;
  int errors = 0;
  logic [31:0] seed = 32'h1234_5678;

  sat_simd_add u_sat_simd_add (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
    .mode_sel(mode_sel), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result), .sat_flags(sat_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic check(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd32();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = rnd32();
    return v;
  endfunction

  function automatic logic [15:0] word_pick(input int k);
    case (k)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;  3: return 16'h7FFE;
      4: return 16'h7FFF;  5: return 16'h8000;  6: return 16'h8001;  7: return 16'hFFFF;
      8: return 16'hFFFE;  9: return 16'h00FF; 10: return 16'h0100; 11: return 16'h4000;
      12: return 16'hC000; 13: return 16'h3FFF; 14: return 16'h7F80; default: return 16'h80FF;
    endcase
  endfunction

  // arithmetic model of the requirements
  task automatic model(input logic sz, input logic [1:0] md, input logic [255:0] a, input logic [255:0] b,
                       output logic [255:0] r, output logic [31:0] f);
    int w = sz ? 16 : 8;
    int lanes = 256 / w;
    if (!md[1]) lanes = lanes / 2;
    r = (md == 2'b00) ? {a[255:128], 128'd0} : '0;
    f = '0;
    for (int i = 0; i < lanes; i++) begin
      int x, y, s;
      if (w == 8) begin
        x = int'($signed(a[8*i +: 8]));
        y = int'($signed(b[8*i +: 8]));
        s = x + y;
        if (s > 127) begin s = 127; f[i] = 1'b1; end
        else if (s < -128) begin s = -128; f[i] = 1'b1; end
        r[8*i +: 8] = s[7:0];
      end else begin
        x = int'($signed(a[16*i +: 16]));
        y = int'($signed(b[16*i +: 16]));
        s = x + y;
        if (s > 32767) begin s = 32767; f[i] = 1'b1; end
        else if (s < -32768) begin s = -32768; f[i] = 1'b1; end
        r[16*i +: 16] = s[15:0];
      end
    end
  endtask

  task automatic do_op(input logic sz, input logic [1:0] md, input logic [255:0] a, input logic [255:0] b, input string tag);
    logic [255:0] er;
    logic [31:0]  ef;
    model(sz, md, a, b, er, ef);
    @(negedge clk);
    size_sel = sz; mode_sel = md; src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R9 out_valid after capture", {255'd0, out_valid}, 256'd1);
    check(result === er, tag, result, er);
    check(sat_flags === ef, "R8 saturation flags", {224'd0, sat_flags}, {224'd0, ef});
  endtask

  initial begin
    logic [255:0] a, b, held;
    rst_n = 1'b0; in_valid = 1'b0; size_sel = 1'b0; mode_sel = 2'b10; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid === 1'b0, "R10 out_valid after reset", {255'd0, out_valid}, 256'd0);

    // R3: carry isolation between neighbouring bytes
    a = {16{16'h00FF}}; b = {16{16'h0001}};
    do_op(1'b0, 2'b10, a, b, "R3 byte carry isolation");
    do_op(1'b1, 2'b10, a, b, "R2 word carry across bytes");

    // R4: explicit clamp corners
    do_op(1'b0, 2'b10, {32{8'h7F}}, {32{8'h01}}, "R4 byte positive clamp");
    do_op(1'b0, 2'b10, {32{8'h80}}, {32{8'hFF}}, "R4 byte negative clamp");
    do_op(1'b1, 2'b11, {16{16'h7FFF}}, {16{16'h0001}}, "R4 word positive clamp");
    do_op(1'b1, 2'b11, {16{16'h8000}}, {16{16'h8000}}, "R4 word negative clamp");

    // R1 and R5: every pair of byte values, full width
    for (int n = 0; n < 2048; n++) begin
      for (int i = 0; i < 32; i++) begin
        int k = n * 32 + i;
        a[8*i +: 8] = k[15:8];
        b[8*i +: 8] = k[7:0];
      end
      do_op(1'b0, 2'b10, a, b, "R1 R5 byte sweep");
    end

    // R2: all pairs of word corner values
    for (int n = 0; n < 16; n++) begin
      for (int i = 0; i < 16; i++) begin
        a[16*i +: 16] = word_pick(n);
        b[16*i +: 16] = word_pick(i);
      end
      do_op(1'b1, 2'b10, a, b, "R2 word corner sweep");
    end

    // R6, R7: narrow forms with random operands, both sizes
    for (int n = 0; n < 100; n++) begin
      do_op(n[0], 2'b01, rnd256(), rnd256(), "R6 zero upper form");
      do_op(n[0], 2'b00, rnd256(), rnd256(), "R7 keep upper form");
      do_op(n[0], 2'b11, rnd256(), rnd256(), "R5 full form alt code");
    end

    // R9: result holds and out_valid drops when in_valid is low
    do_op(1'b0, 2'b10, {32{8'h70}}, {32{8'h70}}, "R4 hold setup");
    held = result;
    @(negedge clk);
    src_a = rnd256(); src_b = rnd256(); mode_sel = 2'b01;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 out_valid low when idle", {255'd0, out_valid}, 256'd0);
    check(result === held, "R9 result holds when idle", result, held);

    // R10: asynchronous assertion of reset
    @(negedge clk);
    size_sel = 1'b0; mode_sel = 2'b10; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1 rst_n = 1'b0;
    #1 check(out_valid === 1'b0, "R10 async reset clears out_valid", {255'd0, out_valid}, 256'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_op(1'b1, 2'b01, rnd256(), rnd256(), "R10 operation after reset");

    finish_run();
  end
endmodule